// File: doc/BRIEF.md
# Seeded Scan-Chain Pattern Filler

This block fills a scan chain with test patterns, each expanded from a short stored seed. A small seed store is written through a simple write port before a run. When a run is started, the block walks the programmed seeds in slot order. For every seed it loads a linear-feedback shift register (LFSR) and then shifts the register's serial output into the chain for exactly as many cycles as the chain is long. It then lowers scan enable for a single capture cycle and moves on to the next seed.

The LFSR uses external feedback. The bit shifted in is the XOR of a fixed set of register bits, chosen when the block is built from a primitive polynomial for the configured width. The register is reloaded from the store at the start of every pattern instead of running freely, so each pattern depends only on its own seed. The register width must be at least the largest number of care bits in any target test cube plus 20. An all-zero seed would lock the register, so the block swaps it for the value 1 and flags the substitution.

Top module: `seed_scan_filler`

## Requirements
- R1: After reset, scan_en, capture, done and seed_err are all low and the block is idle.
- R2: A write with cfg_we high at a rising edge stores cfg_seed in slot cfg_addr. Pattern k of a run, counted from 0, is expanded from slot k.
- R3: In the cycle after start is taken, the block loads the seed. In the following cycle scan_en rises, and it stays high for exactly CHAIN_LEN consecutive cycles.
- R4: During shift, scan_out is the LFSR's most significant bit, so the first bit is seed bit W-1. Each shift cycle the register moves toward the MSB, and bit 0 takes the XOR of the tap bits. For the 24-bit build the tap bits are 23, 22, 21 and 16.
- R5: After each shift window, capture is high and scan_en low for exactly one cycle. Then follows one load cycle with both low, unless the run has ended.
- R6: A run makes min(seed_count, SEED_SLOTS) patterns. done rises in the cycle after the last capture and stays high until the next start. A start pulse during a run is ignored.
- R7: An all-zero seed is replaced by the value 1. The pattern is then the stream that seed 1 gives, and seed_err goes high from the first shift cycle and stays high until the next accepted start clears it.
- R8: A start with seed_count equal to 0 produces no shift cycles, and done is high in the next cycle.
- R9: The LFSR never holds the all-zero state during a shift cycle.
- R10: scan_en and capture are never high together, and neither is high while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Seed store write strobe |
| cfg_addr | input | ADDR_W | Seed slot to write |
| cfg_seed | input | LFSR_W | Seed value to write |
| seed_count | input | CNT_W | Number of patterns for the next run, sampled at start |
| start | input | 1 | Begin a run when idle or done |
| scan_out | output | 1 | Serial data into the scan chain |
| scan_en | output | 1 | Scan chain shift mode |
| capture | output | 1 | One-cycle capture pulse after each pattern |
| done | output | 1 | Run complete |
| seed_err | output | 1 | An all-zero seed was replaced during this run |

## Verification
A wrong LFSR tap or shift direction shows up on scan_out in the shift cycle where the first feedback bit reaches the MSB. That is W cycles into a pattern, so the bench uses a chain longer than the register. A miscounted shift counter changes the number of scan_en cycles before capture and shows within the first pattern. A wrong slot index or pattern count shows either as a pattern compared against the wrong seed or as done rising one capture early or late. A missing zero-seed substitution freezes scan_out at 0 and leaves seed_err low from the first shift cycle.

// File: rtl/ssf_pkg.sv
// Shared types and build-time constants for the seeded scan-chain filler.
// Assumes LFSR widths of at most 64 bits.
package ssf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_CAPT,
        ST_DONE
    } ssf_state_e;

    // Feedback bit mask of a primitive polynomial for a supported width.
    function automatic logic [63:0] tap_mask(input int width);
        logic [63:0] m;
        m = '0;
        case (width)
            20: begin m[19] = 1'b1; m[16] = 1'b1; end
            24: begin m[23] = 1'b1; m[22] = 1'b1; m[21] = 1'b1; m[16] = 1'b1; end
            28: begin m[27] = 1'b1; m[24] = 1'b1; end
            32: begin m[31] = 1'b1; m[21] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
            default: begin m[width-1] = 1'b1; m[width-2] = 1'b1; end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ssf_seed_store.sv
// Seed store: SLOTS registers of W bits, one write port, one combinational read.
// Assumes wr_addr is below SLOTS and clears every slot at reset.
module ssf_seed_store #(
    parameter int W     = 24,
    parameter int SLOTS = 4,
    parameter int AW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Write one slot when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && (wr_addr == AW'(g)))
                slot_q[g] <= wr_data;
        end
    end

    // Read the addressed slot. An out-of-range address reads zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < SLOTS; i++)
            if (rd_addr == AW'(i))
                rd_data = slot_q[i];
    end
endmodule

// File: rtl/ssf_lfsr.sv
// External-feedback LFSR that shifts toward the MSB and outputs the MSB.
// Load has priority over step, and an all-zero seed loads as 1.
module ssf_lfsr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic         msb,
    output logic         zero_seed
);
    import ssf_pkg::*;

    localparam logic [63:0]  TAPS_FULL = tap_mask(W);
    localparam logic [W-1:0] TAPS      = TAPS_FULL[W-1:0];
    localparam logic [W-1:0] SAFE_SEED = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] state_q;
    logic         fb;

    // Feedback is the XOR of the tap bits.
    always_comb fb = ^(state_q & TAPS);

    // Detect a seed that would lock the register.
    always_comb zero_seed = load && (seed == '0);

    // Load a seed, or shift by one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SAFE_SEED;
        else if (load)
            state_q <= zero_seed ? SAFE_SEED : seed;
        else if (step)
            state_q <= {state_q[W-2:0], fb};
    end

    always_comb msb = state_q[W-1];
endmodule

// File: rtl/ssf_sequencer.sv
// Pattern sequencer: load, CHAIN_LEN shift cycles, one capture, repeated for
// each programmed seed, then done. Assumes CHAIN_LEN >= 2.
module ssf_sequencer #(
    parameter int CHAIN_LEN = 16,
    parameter int SLOTS     = 4,
    parameter int CNT_W     = 3,
    parameter int AW        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] seed_count,
    output logic             run_start,
    output logic             load,
    output logic             step,
    output logic [AW-1:0]    slot,
    output logic             scan_en,
    output logic             capture,
    output logic             done
);
    import ssf_pkg::*;

    localparam int LEN_W = $clog2(CHAIN_LEN);

    ssf_state_e        state_q;
    logic [LEN_W-1:0]  bit_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  num_q;
    logic [CNT_W-1:0]  eff_count;

    // Limit the requested count to the store depth.
    always_comb eff_count = (seed_count > CNT_W'(SLOTS)) ? CNT_W'(SLOTS) : seed_count;

    // Start is taken only when no run is active.
    always_comb run_start = start && (state_q == ST_IDLE || state_q == ST_DONE);

    // State, bit counter and pattern index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            idx_q   <= '0;
            num_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (run_start) begin
                        num_q   <= eff_count;
                        idx_q   <= '0;
                        state_q <= (eff_count == '0) ? ST_DONE : ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    bit_q   <= '0;
                    state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    bit_q <= bit_q + 1'b1;
                    if (bit_q == LEN_W'(CHAIN_LEN - 1))
                        state_q <= ST_CAPT;
                end
                ST_CAPT: begin
                    if (idx_q == num_q - 1'b1) begin
                        state_q <= ST_DONE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_LOAD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode controls from the state.
    always_comb begin
        load    = (state_q == ST_LOAD);
        step    = (state_q == ST_SHIFT);
        scan_en = (state_q == ST_SHIFT);
        capture = (state_q == ST_CAPT);
        done    = (state_q == ST_DONE);
        slot    = AW'(idx_q);
    end
endmodule

// File: rtl/seed_scan_filler.sv
// Top: seed store, reloaded LFSR and pattern sequencer.
// Assumes LFSR_W >= largest care-bit count + 20 and LFSR_W <= 64.
module seed_scan_filler #(
    parameter int LFSR_W     = 24,
    parameter int CHAIN_LEN  = 16,
    parameter int SEED_SLOTS = 4,
    parameter int ADDR_W     = (SEED_SLOTS > 1) ? $clog2(SEED_SLOTS) : 1,
    parameter int CNT_W      = $clog2(SEED_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LFSR_W-1:0] cfg_seed,
    input  logic [CNT_W-1:0]  seed_count,
    input  logic              start,
    output logic              scan_out,
    output logic              scan_en,
    output logic              capture,
    output logic              done,
    output logic              seed_err
);
    logic              run_start;
    logic              load;
    logic              step;
    logic [ADDR_W-1:0] slot;
    logic [LFSR_W-1:0] seed;
    logic              zero_seed;

    ssf_seed_store #(.W(LFSR_W), .SLOTS(SEED_SLOTS), .AW(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_seed),
        .rd_addr(slot), .rd_data(seed)
    );

    ssf_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n),
        .load(load), .seed(seed), .step(step),
        .msb(scan_out), .zero_seed(zero_seed)
    );

    ssf_sequencer #(.CHAIN_LEN(CHAIN_LEN), .SLOTS(SEED_SLOTS), .CNT_W(CNT_W), .AW(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .seed_count(seed_count),
        .run_start(run_start), .load(load), .step(step), .slot(slot),
        .scan_en(scan_en), .capture(capture), .done(done)
    );

    // Sticky zero-seed flag, cleared by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seed_err <= 1'b0;
        else if (run_start)
            seed_err <= 1'b0;
        else if (zero_seed)
            seed_err <= 1'b1;
    end
endmodule

// File: rtl/ssf_checker.sv
// Protocol checks for seed_scan_filler, attached with bind.
// Assumes the LFSR register is reachable as u_lfsr.state_q.
module ssf_checker #(
    parameter int W         = 24,
    parameter int CHAIN_LEN = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scan_en,
    input logic         capture,
    input logic         done,
    input logic [W-1:0] lfsr_state
);
    localparam int RUN_W = $clog2(CHAIN_LEN + 1) + 1;

    logic [RUN_W-1:0] run_q;

    // Count consecutive shift cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else
            run_q <= scan_en ? run_q + 1'b1 : '0;
    end

    AST_SHIFT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en) |-> (run_q == RUN_W'(CHAIN_LEN))); // R3
    AST_CAPTURE_FOLLOWS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capture) |-> $past(scan_en)); // R5
    AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture); // R5
    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> (lfsr_state != '0)); // R9
    AST_EN_CAPTURE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_en && capture)); // R10
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scan_en && !capture)); // R10
endmodule

bind seed_scan_filler ssf_checker #(.W(LFSR_W), .CHAIN_LEN(CHAIN_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .scan_en(scan_en), .capture(capture), .done(done),
    .lfsr_state(u_lfsr.state_q)
);

// File: tb/test_seed_scan_filler.sv
module test_seed_scan_filler;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 24;
    localparam int M     = 32;   // longer than W so the feedback reaches scan_out
    localparam int SLOTS = 4;
    localparam int AW    = 2;
    localparam int CW    = 3;
    localparam logic [W-1:0] TAPS = 24'hE1_0000; // bits 23,22,21,16

    // Stimulus table: the seed written to each slot. The expected stream of
    // each pattern is computed from it by the model below.
    localparam logic [W-1:0] SEED_TAB [SLOTS] = '{24'hA5_0F3C, 24'h80_0001, 24'hFF_FFFF, 24'h12_3456};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [W-1:0] cfg_seed = '0;
    logic [CW-1:0] seed_count = '0;
    logic start = 1'b0;
    logic scan_out, scan_en, capture, done, seed_err;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] exp_seed [SLOTS];

    always #(CLK_PERIOD/2) clk = ~clk;

    seed_scan_filler #(.LFSR_W(W), .CHAIN_LEN(M), .SEED_SLOTS(SLOTS)) i_seed_scan_filler (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_seed(cfg_seed),
        .seed_count(seed_count), .start(start), .scan_out(scan_out), .scan_en(scan_en),
        .capture(capture), .done(done), .seed_err(seed_err)
    );

    function automatic logic [M-1:0] model_stream(input logic [W-1:0] s0);
        logic [W-1:0] s = s0;
        logic [M-1:0] r = '0;
        for (int j = 0; j < M; j++) begin
            r = {r[M-2:0], s[W-1]};
            s = {s[W-2:0], ^(s & TAPS)};
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_seed(input int a, input logic [W-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_seed = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Start a run and check every pattern against exp_seed.
    task automatic run_batch(input int cnt_req, input int n_exp, input int inject_at);
        int pat = 0;
        int bits = 0;
        int cyc = 0;
        logic [M-1:0] stream = '0;
        logic prev_cap = 1'b0;
        @(negedge clk);
        seed_count = CW'(cnt_req); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R3: load cycle, nothing shifting yet
        check("R3 load cycle scan_en", {63'd0, scan_en}, 64'd0);
        while (cyc < 5000) begin
            @(negedge clk);
            cyc++;
            start = (cyc == inject_at);  // R6: stray start during the run
            if (prev_cap && !done) begin
                check("R5 load gap after capture", {62'd0, scan_en, capture}, 64'd0);
            end
            if (scan_en) begin
                stream = {stream[M-2:0], scan_out};
                bits++;
            end
            if (capture) begin
                check("R3 shift cycle count", 64'(bits), 64'(M));
                check("R4 R2 pattern stream", 64'(stream), 64'(model_stream(exp_seed[pat % SLOTS])));
                pat++;
                bits = 0;
            end
            prev_cap = capture;
            if (done) break;
        end
        start = 1'b0;
        check("R6 pattern count", 64'(pat), 64'(n_exp));
        check("R6 done after last capture", {63'd0, done}, 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 scan_en", {63'd0, scan_en}, 64'd0);
        check("R1 capture", {63'd0, capture}, 64'd0);
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 seed_err", {63'd0, seed_err}, 64'd0);
        rst_n = 1'b1;

        // Table walk: program every slot, run all of them.
        for (int i = 0; i < SLOTS; i++) begin
            write_seed(i, SEED_TAB[i]);
            exp_seed[i] = SEED_TAB[i];
        end
        run_batch(SLOTS, SLOTS, 0);
        check("R7 no error on nonzero seeds", {63'd0, seed_err}, 64'd0);

        // R6: done is held while idle
        repeat (5) @(negedge clk);
        check("R6 done held", {63'd0, done}, 64'd1);

        // R6: partial count, with a stray start mid-run that must be ignored
        run_batch(2, 2, 40);

        // R6: count above the store depth is limited to the depth
        run_batch(7, SLOTS, 0);

        // R7 R9: zero seed replaced by 1, flag raised
        write_seed(0, '0);
        exp_seed[0] = 24'h00_0001;
        run_batch(1, 1, 0);
        check("R7 seed_err set", {63'd0, seed_err}, 64'd1);
        repeat (3) @(negedge clk);
        check("R7 seed_err sticky", {63'd0, seed_err}, 64'd1);

        // R8: zero count finishes at once; R7: the start clears seed_err
        @(negedge clk);
        seed_count = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 done next cycle", {63'd0, done}, 64'd1);
        check("R8 no shift", {63'd0, scan_en}, 64'd0);
        check("R7 seed_err cleared by start", {63'd0, seed_err}, 64'd0);

        // R2: rewrite a single slot and use it
        write_seed(0, 24'h5A_C3E7);
        exp_seed[0] = 24'h5A_C3E7;
        run_batch(1, 1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule